// File: doc/BRIEF.md
# Read Strobe Delay Calibration Sweep

This block finds the read strobe delay for each of two byte-wide data slices of a DDR3 interface. On a start request it sends a mode-register write that switches the memory into its fixed training-pattern mode. It then steps every slice's delay up from zero, one tap per read. Each read returns one byte per slice. That byte is compared against the value the training pattern produces on the strobe edge chosen at start.

For each slice the block records the first and the last delay at which every bit of the byte matched. It programs the midpoint of these two delays, then writes the mode register back to normal operation and pulses done. A slice whose byte never matched raises its error bit and keeps the delay it had before the sweep.

The PHY delay line and the memory device are outside the block. Mode-register writes and read requests are single-cycle command pulses. Every read is answered by one response strobe that carries both slices' bytes.

Top module: `rdlvl_sweep`

## Requirements
- R1: An accepted start first issues a mode-register write with `mr_sel_o` = 3 and `mr_data_o` = 0x0004, before any read request.
- R2: At the start of the sweep every slice's delay is 0. Each still-sweeping slice's delay rises by exactly one between consecutive read requests. Read request k (from 0) is made with delay k on every slice that is still sweeping.
- R3: A response byte passes only when all 8 bits equal the expected value: 0x00 when `edge_sel_i` was 0 at start, 0xFF when it was 1. A byte with even one differing bit fails.
- R4: A slice that passed at least once gets the final delay (lowest passing + highest passing) >> 1, rounded down.
- R5: A slice stops sweeping at its first failing read after a passing read, or after the read at the maximum delay (127). The sweep ends once no slice is still sweeping, so the number of reads is the largest of the slices' stop points.
- R6: A slice that never passes sets its bit in `err_o` (bit 0 = slice 0) and keeps the delay it held before the start. Error bits clear on the next start.
- R7: Before `done_o` the block issues a mode-register write with `mr_sel_o` = 3 and `mr_data_o` = 0x0000, whether or not an error occurred. `done_o` is high for exactly one cycle, directly after that write. Each run issues exactly two mode-register writes.
- R8: After reset there are no commands, `done_o` and `err_o` are 0, and all delays are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; taken only when idle |
| edge_sel_i | input | 1 | Strobe edge under calibration, captured at start (0 rising, 1 falling) |
| cmd_mrw_o | output | 1 | One-cycle mode-register write command |
| cmd_rd_o | output | 1 | One-cycle read command |
| mr_sel_o | output | 3 | Mode register index for the write |
| mr_data_o | output | 16 | Mode register value for the write |
| resp_valid_i | input | 1 | Read response strobe |
| resp_i | input | 16 | Sampled response bytes, slice 0 in bits 7:0 |
| delay_o | output | 14 | Read strobe delays, slice 0 in bits 6:0 |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Per-slice no-pass error flags |

## Verification
The bound checker watches several properties on every cycle: the two command kinds never overlap, every mode-register write targets register 3 with one of the two legal values, done lasts a single cycle and always follows the restoring write, and a delay never moves by anything other than zero or one tap while the sweep runs. Only the bench scenarios can show the rest, because it depends on the modelled pass window of each slice. This covers the exact final midpoints, the rounding, the point at which the sweep stops, the error flags, the retained delays after a failed slice, and the edge-dependent expected byte, including responses with just one wrong bit.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
  localparam int MR_SEL_W  = 3;
  localparam int MR_DATA_W = 16;
  localparam logic [MR_SEL_W-1:0]  MR_TRAIN_SEL = 3'd3;
  localparam logic [MR_DATA_W-1:0] MR_PAT_ON    = 16'h0004;
  localparam logic [MR_DATA_W-1:0] MR_PAT_OFF   = 16'h0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MR_ON,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_STEP,
    ST_MR_OFF,
    ST_DONE
  } sweep_state_e;
endpackage

// File: rtl/rdlvl_ctrl.sv
module rdlvl_ctrl
  import rdlvl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 edge_sel_i,
  input  logic                 resp_valid_i,
  input  logic                 any_active_i,
  output logic                 init_o,
  output logic                 eval_o,
  output logic                 step_o,
  output logic                 fin_o,
  output logic                 edge_o,
  output logic                 busy_o,
  output logic                 cmd_mrw_o,
  output logic                 cmd_rd_o,
  output logic [MR_SEL_W-1:0]  mr_sel_o,
  output logic [MR_DATA_W-1:0] mr_data_o,
  output logic                 done_o
);
  sweep_state_e state_q, state_d;
  logic edge_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_MR_ON;
      ST_MR_ON:   state_d = ST_RD_REQ;
      ST_RD_REQ:  state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (resp_valid_i) state_d = ST_STEP;
      ST_STEP:    state_d = any_active_i ? ST_RD_REQ : ST_MR_OFF;
      ST_MR_OFF:  state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (init_o) edge_q <= edge_sel_i;
    end
  end

  assign init_o    = (state_q == ST_IDLE) && start_i;
  assign eval_o    = (state_q == ST_RD_WAIT) && resp_valid_i;
  assign step_o    = (state_q == ST_STEP) && any_active_i;
  assign fin_o     = (state_q == ST_MR_OFF);
  assign edge_o    = edge_q;
  assign busy_o    = (state_q == ST_MR_ON) || (state_q == ST_RD_REQ) ||
                     (state_q == ST_RD_WAIT) || (state_q == ST_STEP);
  assign cmd_mrw_o = (state_q == ST_MR_ON) || (state_q == ST_MR_OFF);
  assign cmd_rd_o  = (state_q == ST_RD_REQ);
  assign mr_sel_o  = MR_TRAIN_SEL;
  assign mr_data_o = (state_q == ST_MR_ON) ? MR_PAT_ON : MR_PAT_OFF;
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/rdlvl_slice.sv
module rdlvl_slice #(
  parameter int DQ_W    = 8,
  parameter int DLY_W   = 7,
  parameter int RST_DLY = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             eval_i,
  input  logic             step_i,
  input  logic             fin_i,
  input  logic             edge_i,
  input  logic [DQ_W-1:0]  resp_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             active_o,
  output logic             err_o
);
  localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

  logic [DLY_W-1:0] dly_q, save_q, lo_q, hi_q;
  logic             seen_q, active_q, err_q;
  logic             pass;
  logic [DLY_W:0]   sum;

  assign pass = (resp_i == {DQ_W{edge_i}});
  assign sum  = {1'b0, lo_q} + {1'b0, hi_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= DLY_W'(RST_DLY);
      save_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      seen_q   <= 1'b0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (init_i) begin
      save_q   <= dly_q;
      dly_q    <= '0;
      seen_q   <= 1'b0;
      active_q <= 1'b1;
      err_q    <= 1'b0;
    end else if (eval_i && active_q) begin
      if (pass) begin
        if (!seen_q) lo_q <= dly_q;
        hi_q   <= dly_q;
        seen_q <= 1'b1;
      end
      // stop at first fail after a pass, or at the top of the range
      if ((!pass && seen_q) || (dly_q == DLY_MAX)) active_q <= 1'b0;
    end else if (step_i && active_q) begin
      dly_q <= dly_q + 1'b1;
    end else if (fin_i) begin
      dly_q    <= seen_q ? sum[DLY_W:1] : save_q;
      err_q    <= !seen_q;
      active_q <= 1'b0;
    end
  end

  assign dly_o    = dly_q;
  assign active_o = active_q;
  assign err_o    = err_q;
endmodule

// File: rtl/rdlvl_sweep.sv
module rdlvl_sweep
  import rdlvl_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  parameter int DQ_W       = 8,
  parameter int DLY_W      = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        edge_sel_i,
  output logic                        cmd_mrw_o,
  output logic                        cmd_rd_o,
  output logic [2:0]                  mr_sel_o,
  output logic [15:0]                 mr_data_o,
  input  logic                        resp_valid_i,
  input  logic [NUM_SLICES*DQ_W-1:0]  resp_i,
  output logic [NUM_SLICES*DLY_W-1:0] delay_o,
  output logic                        done_o,
  output logic [NUM_SLICES-1:0]       err_o
);
  logic init, eval, step, fin, edge_sel, sweep_busy, any_active;
  logic [NUM_SLICES-1:0] active;

  assign any_active = |active;

  rdlvl_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .edge_sel_i   (edge_sel_i),
    .resp_valid_i (resp_valid_i),
    .any_active_i (any_active),
    .init_o       (init),
    .eval_o       (eval),
    .step_o       (step),
    .fin_o        (fin),
    .edge_o       (edge_sel),
    .busy_o       (sweep_busy),
    .cmd_mrw_o    (cmd_mrw_o),
    .cmd_rd_o     (cmd_rd_o),
    .mr_sel_o     (mr_sel_o),
    .mr_data_o    (mr_data_o),
    .done_o       (done_o)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    rdlvl_slice #(.DQ_W(DQ_W), .DLY_W(DLY_W)) i_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .init_i   (init),
      .eval_i   (eval),
      .step_i   (step),
      .fin_i    (fin),
      .edge_i   (edge_sel),
      .resp_i   (resp_i[s*DQ_W +: DQ_W]),
      .dly_o    (delay_o[s*DLY_W +: DLY_W]),
      .active_o (active[s]),
      .err_o    (err_o[s])
    );
  end
endmodule

// File: rtl/rdlvl_sweep_chk.sv
module rdlvl_sweep_chk #(
  parameter int NUM_SLICES = 2,
  parameter int DLY_W      = 7
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cmd_mrw_o,
  input logic                        cmd_rd_o,
  input logic [2:0]                  mr_sel_o,
  input logic [15:0]                 mr_data_o,
  input logic                        done_o,
  input logic                        sweep_busy,
  input logic [NUM_SLICES*DLY_W-1:0] delay_o
);
  assert_cmd_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_mrw_o && cmd_rd_o));

  assert_mr_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_mrw_o |-> (mr_sel_o == 3'd3) && (mr_data_o == 16'h0004 || mr_data_o == 16'h0000));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_mrw_o) && ($past(mr_data_o) == 16'h0000));

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_step
    assert_dly_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sweep_busy && $past(sweep_busy)) |->
        (delay_o[s*DLY_W +: DLY_W] == $past(delay_o[s*DLY_W +: DLY_W])) ||
        (delay_o[s*DLY_W +: DLY_W] == $past(delay_o[s*DLY_W +: DLY_W]) + DLY_W'(1)));
  end
endmodule

bind rdlvl_sweep rdlvl_sweep_chk #(.NUM_SLICES(NUM_SLICES), .DLY_W(DLY_W)) i_chk (.*);

// File: tb/test_rdlvl_sweep.sv
module test_rdlvl_sweep;
  localparam int NS = 2;
  localparam int DQ_W = 8;
  localparam int DLY_W = 7;
  localparam int MAXD = 127;
  localparam logic [7:0] NONE = 8'hFF;

  typedef struct packed {
    logic       edg;
    logic [7:0] lo0, hi0, lo1, hi1, m0, m1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1,   8'd64,  8'd1,   8'd64,  8'hFF, 8'hFF},
    '{1'b1, 8'd10,  8'd40,  8'd20,  8'd90,  8'h01, 8'h80},
    '{1'b0, 8'd3,   8'd8,   8'd100, 8'd127, 8'h10, 8'hFF},
    '{1'b1, NONE,   NONE,   8'd5,   8'd6,   8'hFF, 8'h10},
    '{1'b0, NONE,   NONE,   NONE,   NONE,   8'h02, 8'hFF},
    '{1'b0, 8'd127, 8'd127, 8'd2,   8'd3,   8'hFF, 8'h40}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, edge_sel_i = 1'b0;
  logic cmd_mrw_o, cmd_rd_o, resp_valid_i = 1'b0, done_o;
  logic [2:0] mr_sel_o;
  logic [15:0] mr_data_o;
  logic [NS*DQ_W-1:0] resp_i = '0;
  logic [NS*DLY_W-1:0] delay_o;
  logic [NS-1:0] err_o;

  always #2 clk_i = ~clk_i;

  rdlvl_sweep i_rdlvl_sweep (.*);

  int n_chk = 0, n_fail = 0;
  vec_t cur;
  int rd_cnt, mrw_cnt, mrw_first, mrw_last, mrw_bad_sel, mrw_at_first_rd, step_bad;
  int stop_pt [NS];
  int prev_dly [NS];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dly_of(int s);
    return int'(delay_o[s*DLY_W +: DLY_W]);
  endfunction

  function automatic logic [7:0] resp_for(int s, int d);
    logic [7:0] lo, hi, m, pat;
    lo  = (s == 0) ? cur.lo0 : cur.lo1;
    hi  = (s == 0) ? cur.hi0 : cur.hi1;
    m   = (s == 0) ? cur.m0  : cur.m1;
    pat = {8{cur.edg}};
    if (lo != NONE && d >= int'(lo) && d <= int'(hi)) return pat;
    return pat ^ m;
  endfunction

  // memory + PHY model: answers each read two cycles later
  initial begin
    forever begin
      @(negedge clk_i);
      if (cmd_rd_o) begin
        @(negedge clk_i);
        @(negedge clk_i);
        for (int s = 0; s < NS; s++) resp_i[s*DQ_W +: DQ_W] = resp_for(s, dly_of(s));
        resp_valid_i = 1'b1;
        @(negedge clk_i);
        resp_valid_i = 1'b0;
      end
    end
  end

  // command monitor
  always @(negedge clk_i) begin
    if (rst_ni && cmd_rd_o) begin
      if (rd_cnt == 0) mrw_at_first_rd = mrw_cnt;
      for (int s = 0; s < NS; s++)
        if (rd_cnt < stop_pt[s] && dly_of(s) != rd_cnt) step_bad++;
      rd_cnt++;
    end
    if (rst_ni && cmd_mrw_o) begin
      if (mrw_cnt == 0) mrw_first = int'(mr_data_o);
      mrw_last = int'(mr_data_o);
      if (mr_sel_o != 3'd3) mrw_bad_sel++;
      mrw_cnt++;
    end
  end

  task automatic run_vec(vec_t v, int idx);
    int exp_dly [NS];
    int exp_err, exp_reads, wait_cyc;
    logic [7:0] lo, hi;
    cur = v;
    exp_err = 0;
    exp_reads = 0;
    for (int s = 0; s < NS; s++) begin
      lo = (s == 0) ? v.lo0 : v.lo1;
      hi = (s == 0) ? v.hi0 : v.hi1;
      if (lo == NONE) begin
        stop_pt[s] = MAXD + 1;
        exp_dly[s] = prev_dly[s];
        exp_err |= (1 << s);
      end else begin
        stop_pt[s] = (int'(hi) == MAXD) ? MAXD + 1 : int'(hi) + 2;
        exp_dly[s] = (int'(lo) + int'(hi)) >> 1;
      end
      if (stop_pt[s] > exp_reads) exp_reads = stop_pt[s];
    end
    rd_cnt = 0; mrw_cnt = 0; mrw_first = -1; mrw_last = -1;
    mrw_bad_sel = 0; mrw_at_first_rd = -1; step_bad = 0;
    @(negedge clk_i);
    edge_sel_i = v.edg;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    edge_sel_i = ~v.edg;
    wait_cyc = 0;
    while (!done_o && wait_cyc < 5000) begin
      @(negedge clk_i);
      wait_cyc++;
    end
    if (!done_o) begin
      n_chk++; n_fail++;
      $display("FAIL R7: vector %0d no done, got 0 expected 1", idx);
      return;
    end
    chk($sformatf("R4/R6 vec%0d slice0 delay", idx), dly_of(0), exp_dly[0]);
    chk($sformatf("R4/R6 vec%0d slice1 delay", idx), dly_of(1), exp_dly[1]);
    chk($sformatf("R6 vec%0d err", idx), int'(err_o), exp_err);
    chk($sformatf("R5 vec%0d read count", idx), rd_cnt, exp_reads);
    chk($sformatf("R2 vec%0d delay per read", idx), step_bad, 0);
    chk($sformatf("R1 vec%0d pattern-on write", idx), mrw_first, 16'h0004);
    chk($sformatf("R1 vec%0d write before first read", idx), mrw_at_first_rd, 1);
    chk($sformatf("R7 vec%0d restore write", idx), mrw_last, 0);
    chk($sformatf("R7 vec%0d write count", idx), mrw_cnt, 2);
    chk($sformatf("R1 vec%0d register index", idx), mrw_bad_sel, 0);
    @(negedge clk_i);
    chk($sformatf("R7 vec%0d done one cycle", idx), int'(done_o), 0);
    for (int s = 0; s < NS; s++) prev_dly[s] = exp_dly[s];
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin prev_dly[s] = 0; stop_pt[s] = 0; end
    rd_cnt = 0; mrw_cnt = 0; step_bad = 0; mrw_bad_sel = 0;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 done after reset", int'(done_o), 0);
    chk("R8 err after reset", int'(err_o), 0);
    chk("R8 delays after reset", int'(delay_o), 0);
    chk("R8 no command in reset", int'(cmd_mrw_o) + int'(cmd_rd_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R8 idle without start", rd_cnt + mrw_cnt, 0);
    // R3 one flipped bit fails, edge select picks 0x00 or 0xFF: covered by the masks in the table
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    // R6 error bits clear on a passing restart
    run_vec(VECS[0], NV);
    chk("R6 error cleared on restart", int'(err_o), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule